// File: doc/BRIEF.md
# Direct-Mapped Instruction Prefetch Cache

This block sits between a processor's instruction prefetch port and an external memory bus. The processor asks for one 16-bit instruction word at a time. Each request carries a 32-bit byte address and a supervisor/user space bit. The cache has 64 lines. Each line holds one aligned 32-bit long word, so it covers two instruction words. The stored tag is the upper address bits 31:8 together with the space bit.

A hit returns the word in the same cycle as the request. On a miss the block reads the aligned long word from the bus, writes it into the indexed line and returns the requested half. While the cache is disabled, every fetch goes to the bus and the stored contents are neither looked up nor written. A single-cycle invalidate input drops every line.

Top module: `ifetch_dm_cache`

## Requirements
- R1: The line index is `req_addr[7:2]`, giving 64 lines. A fill replaces whatever the indexed line held before, so two addresses with equal bits 7:2 but different bits 31:8 evict each other.
- R2: A lookup hits only when the line's stored tag `{space bit, addr[31:8]}` equals `{req_super, req_addr[31:8]}`. Addresses that differ only in bits 31:24, or only in the space bit, miss each other's line.
- R3: A lookup hits only if the line's valid bit is set. A line that has never been filled always misses.
- R4: On a hit with the cache enabled, `resp_ready` is high in the same cycle as `req_valid` and no bus read is made. `req_addr[1]`=0 returns line bits 15:0, `req_addr[1]`=1 returns bits 31:16, and `req_addr[0]` has no effect.
- R5: A miss raises `bus_req` one cycle after the request, with `bus_addr` = `{req_addr[31:2],2'b00}`. It holds both until `bus_ack`, then raises `resp_ready` in the cycle after the acknowledge, carrying the requested half of `bus_data`.
- R6: A miss taken while the cache is enabled fills the indexed line with the data, the tag and the space bit, and sets its valid bit. A later fetch from the same line hits.
- R7: While `cache_en` is low, every fetch is a bus read and nothing is written into the cache. Lines filled earlier still hit once the cache is enabled again.
- R8: A one-cycle `inv_all` pulse clears every valid bit. A fetch presented in the same cycle as the pulse is treated as a miss. A fill whose acknowledge coincides with the pulse leaves the line invalid.
- R9: After reset, `resp_ready` and `bus_req` are low and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Cache use enable |
| inv_all | input | 1 | One-cycle pulse that invalidates all lines |
| req_valid | input | 1 | Fetch request, held until `resp_ready` |
| req_addr | input | 32 | Byte address of the requested instruction word |
| req_super | input | 1 | Space bit, 1 = supervisor, 0 = user |
| resp_ready | output | 1 | Fetch complete, `resp_data` valid |
| resp_data | output | 16 | Returned instruction word |
| bus_req | output | 1 | External long-word read request |
| bus_addr | output | 32 | Aligned long-word address |
| bus_ack | input | 1 | External read acknowledge, `bus_data` valid |
| bus_data | input | 32 | External read data |

## Verification
The hardest cases to reach from the ports are the two collisions with invalidate. In one, the pulse arrives in the same cycle as a fetch that would otherwise hit. In the other, it lands exactly on the bus acknowledge of a fill. The bench can place the pulse on either of those two cycles, and it also mixes such fetches into a random stream. Random fetches draw from a small pool of upper-address patterns so that lines are reused. The pool includes patterns that differ only in bits 31:24 and in the space bit, so aliasing in the tag is exercised throughout.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_DONE  = 2'd2
   } fetch_st_e;
endpackage

// File: rtl/ifc_tag_store.sv
module ifc_tag_store #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6,
   parameter int TAG_W   = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inv_all,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);
   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (inv_all) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
      end
   end

   assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

   p_inv_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (valid_q == '0));
   p_fill_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !inv_all) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/ifc_line_store.sv
module ifc_line_store #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6,
   parameter int LINE_W  = 32
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LINE_W-1:0] wr_line,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [LINE_W-1:0] rd_line
);
   logic [LINE_W-1:0] line_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         line_q[wr_idx] <= wr_line;
      end
   end

   assign rd_line = line_q[rd_idx];
endmodule

// File: rtl/ifc_word_pick.sv
module ifc_word_pick #(
   parameter int LINE_W = 32,
   parameter int WORD_W = 16,
   parameter int SEL_W  = 1
) (
   input  logic [LINE_W-1:0] line_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int WPL = LINE_W / WORD_W;

   if (WPL == 2) begin : g_pair
      assign word_o = sel_i[0] ? line_i[2*WORD_W-1:WORD_W] : line_i[WORD_W-1:0];
   end else begin : g_many
      logic [WORD_W-1:0] words [WPL];
      for (genvar w = 0; w < WPL; w++) begin : g_split
         assign words[w] = line_i[w*WORD_W +: WORD_W];
      end
      assign word_o = words[sel_i];
   end
endmodule

// File: rtl/ifc_fetch_ctrl.sv
module ifc_fetch_ctrl
   import ifc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LINE_W  = 32,
   parameter int BYTE_LO = 1,
   parameter int OFF_W   = 2,
   parameter int TAG_LO  = 8,
   parameter int TAG_W   = 25,
   parameter int IDX_W   = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cache_en,
   input  logic                     inv_all,
   input  logic                     req_valid,
   input  logic [ADDR_W-1:BYTE_LO]  req_addr,
   input  logic                     req_super,
   input  logic                     lk_hit,
   input  logic                     bus_ack,
   input  logic [LINE_W-1:0]        bus_data,
   output logic                     resp_ready,
   output logic                     use_cache,
   output logic                     bus_req,
   output logic [ADDR_W-1:0]        bus_addr,
   output logic                     fill_en,
   output logic [IDX_W-1:0]         fill_idx,
   output logic [TAG_W-1:0]         fill_tag,
   output logic [LINE_W-1:0]        held_line,
   output logic [OFF_W-1:BYTE_LO]   held_sel
);
   fetch_st_e                 state_q;
   logic [ADDR_W-1:BYTE_LO]   addr_q;
   logic                      sup_q;
   logic                      en_q;
   logic [LINE_W-1:0]         line_q;
   logic                      hit_now;

   assign hit_now = req_valid && cache_en && lk_hit && !inv_all;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE:  if (req_valid && !hit_now) state_q <= ST_FETCH;
            ST_FETCH: if (bus_ack) state_q <= ST_DONE;
            ST_DONE:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (state_q == ST_IDLE && req_valid && !hit_now) begin
         addr_q <= req_addr;
         sup_q  <= req_super;
         en_q   <= cache_en;
      end
      if (state_q == ST_FETCH && bus_ack) begin
         line_q <= bus_data;
      end
   end

   assign use_cache  = (state_q == ST_IDLE) && hit_now;
   assign resp_ready = use_cache || (state_q == ST_DONE);
   assign bus_req    = (state_q == ST_FETCH);
   assign bus_addr   = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign fill_en    = (state_q == ST_FETCH) && bus_ack && en_q && !inv_all;
   assign fill_idx   = addr_q[TAG_LO-1:OFF_W];
   assign fill_tag   = {sup_q, addr_q[ADDR_W-1:TAG_LO]};
   assign held_line  = line_q;
   assign held_sel   = addr_q[OFF_W-1:BYTE_LO];

   p_bus_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));
   p_ack_to_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack) |=> resp_ready);
   p_bus_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_addr[OFF_W-1:0] == '0));
   p_hit_no_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
      resp_ready |-> !bus_req);
   p_off_to_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && req_valid && !cache_en) |=> bus_req);
endmodule

// File: rtl/ifetch_dm_cache.sv
module ifetch_dm_cache #(
   parameter int ADDR_W  = 32,
   parameter int WORD_W  = 16,
   parameter int LINE_W  = 32,
   parameter int ENTRIES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cache_en,
   input  logic              inv_all,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_super,
   output logic              resp_ready,
   output logic [WORD_W-1:0] resp_data,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_ack,
   input  logic [LINE_W-1:0] bus_data
);
   localparam int OFF_W   = $clog2(LINE_W / 8);
   localparam int BYTE_LO = $clog2(WORD_W / 8);
   localparam int IDX_W   = $clog2(ENTRIES);
   localparam int TAG_LO  = OFF_W + IDX_W;
   localparam int TAG_W   = ADDR_W - TAG_LO + 1;
   localparam int SEL_W   = OFF_W - BYTE_LO;

   if ((LINE_W <= WORD_W) || (LINE_W % WORD_W != 0) || (WORD_W % 8 != 0)
       || ((1 << OFF_W) != LINE_W / 8) || ((1 << BYTE_LO) != WORD_W / 8)
       || ((1 << IDX_W) != ENTRIES) || (TAG_LO >= ADDR_W)) begin : g_bad_cfg
      $error("ifetch_dm_cache: unsupported width or depth parameters");
   end

   if (BYTE_LO > 0) begin : g_lsb
      logic unused_lsb;
      assign unused_lsb = ^req_addr[BYTE_LO-1:0];
   end

   logic              lk_hit;
   logic              use_cache;
   logic              fill_en;
   logic [IDX_W-1:0]  fill_idx;
   logic [TAG_W-1:0]  fill_tag;
   logic [LINE_W-1:0] held_line;
   logic [SEL_W-1:0]  held_sel;
   logic [LINE_W-1:0] rd_line;
   logic [WORD_W-1:0] cache_word;
   logic [WORD_W-1:0] bus_word;
   logic [IDX_W-1:0]  lk_idx;
   logic [TAG_W-1:0]  lk_tag;

   assign lk_idx = req_addr[TAG_LO-1:OFF_W];
   assign lk_tag = {req_super, req_addr[ADDR_W-1:TAG_LO]};

   ifc_tag_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
      .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
      .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
      .wr_en(fill_en), .wr_idx(fill_idx), .wr_tag(fill_tag));

   ifc_line_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .LINE_W(LINE_W)) lines_i (
      .clk(clk), .wr_en(fill_en), .wr_idx(fill_idx), .wr_line(held_line_next()),
      .rd_idx(lk_idx), .rd_line(rd_line));

   function automatic logic [LINE_W-1:0] held_line_next();
      return bus_data;
   endfunction

   ifc_fetch_ctrl #(
      .ADDR_W(ADDR_W), .LINE_W(LINE_W), .BYTE_LO(BYTE_LO), .OFF_W(OFF_W),
      .TAG_LO(TAG_LO), .TAG_W(TAG_W), .IDX_W(IDX_W)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .inv_all(inv_all),
      .req_valid(req_valid), .req_addr(req_addr[ADDR_W-1:BYTE_LO]),
      .req_super(req_super), .lk_hit(lk_hit), .bus_ack(bus_ack),
      .bus_data(bus_data), .resp_ready(resp_ready), .use_cache(use_cache),
      .bus_req(bus_req), .bus_addr(bus_addr), .fill_en(fill_en),
      .fill_idx(fill_idx), .fill_tag(fill_tag), .held_line(held_line),
      .held_sel(held_sel));

   ifc_word_pick #(.LINE_W(LINE_W), .WORD_W(WORD_W), .SEL_W(SEL_W)) pick_hit_i (
      .line_i(rd_line), .sel_i(req_addr[OFF_W-1:BYTE_LO]), .word_o(cache_word));

   ifc_word_pick #(.LINE_W(LINE_W), .WORD_W(WORD_W), .SEL_W(SEL_W)) pick_miss_i (
      .line_i(held_line), .sel_i(held_sel), .word_o(bus_word));

   assign resp_data = use_cache ? cache_word : bus_word;

   p_off_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cache_en |-> !use_cache);
   p_inv_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |-> !use_cache);
endmodule

// File: tb/ifetch_dm_cache_tb_top.sv
module ifetch_dm_cache_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cache_en = 1'b1;
   logic        inv_all = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_super = 1'b0;
   logic        resp_ready;
   logic [15:0] resp_data;
   logic        bus_req;
   logic [31:0] bus_addr;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_data = '0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   bit          m_valid [64];
   logic [24:0] m_tag   [64];

   always #10 clk = ~clk;

   ifetch_dm_cache dut_i (
      .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .inv_all(inv_all),
      .req_valid(req_valid), .req_addr(req_addr), .req_super(req_super),
      .resp_ready(resp_ready), .resp_data(resp_data), .bus_req(bus_req),
      .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_data(bus_data));

   function automatic logic [31:0] mem_of(logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ {a[15:0], a[31:16]} ^ 32'h5A5A_1234;
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 64; i++) m_valid[i] = 0;
   endtask

   task automatic pulse_inv();
      @(negedge clk); inv_all = 1'b1;
      @(posedge clk);
      @(negedge clk); inv_all = 1'b0;
      model_clear();
   endtask

   // invm: 0 none, 1 pulse with the request, 2 pulse on the bus acknowledge
   task automatic fetch(logic [31:0] a, logic s, int dly, int invm, string req);
      int          idx = int'(a[7:2]);
      logic [24:0] tg = {s, a[31:8]};
      logic [31:0] line = mem_of({a[31:2], 2'b00});
      logic [15:0] exp_w = a[1] ? line[31:16] : line[15:0];
      bit          exp_hit;
      bit          got = 0, used = 0;
      int          cyc = 0, waited = 0;
      logic [15:0] data = '0;
      logic [31:0] baddr = '0;
      if (invm == 1) model_clear();
      exp_hit = cache_en && (invm != 1) && m_valid[idx] && (m_tag[idx] == tg);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_super = s;
      if (invm == 1) inv_all = 1'b1;
      while (!got && cyc < 60) begin
         #1;
         if (resp_ready) begin
            got = 1; data = resp_data;
         end else if (bus_req) begin
            used = 1; baddr = bus_addr;
            if (waited >= dly) begin
               bus_ack = 1'b1; bus_data = mem_of(bus_addr);
               if (invm == 2) inv_all = 1'b1;
            end else waited++;
         end
         @(posedge clk);
         @(negedge clk);
         bus_ack = 1'b0; inv_all = 1'b0;
         if (!got) cyc++;
      end
      req_valid = 1'b0;
      check({req, " R2 R3"}, "bus read used (1=miss)", 32'(used), 32'(!exp_hit));
      check({req, " R4"}, "returned word", 32'(data), 32'(exp_w));
      check({req, " R5"}, "cycles to ready", cyc, exp_hit ? 0 : 2 + dly);
      if (!exp_hit)
         check({req, " R5"}, "bus address", baddr, {a[31:2], 2'b00});
      if (invm == 2) model_clear();
      else if (!exp_hit && cache_en) begin
         m_valid[idx] = 1; m_tag[idx] = tg;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=expired expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check("R9", "resp_ready after reset", 32'(resp_ready), 0);
      check("R9", "bus_req after reset", 32'(bus_req), 0);

      // R3 R9: empty cache misses; R6: refetch hits
      fetch(32'h0000_1000, 0, 0, 0, "R3");
      fetch(32'h0000_1000, 0, 0, 0, "R6");
      // R4: halves and ignored bit 0
      fetch(32'h0000_1002, 0, 0, 0, "R4");
      fetch(32'h0000_1003, 0, 0, 0, "R4");
      fetch(32'h0000_1001, 0, 0, 0, "R4");
      // R2: upper-byte alias and space bit
      fetch(32'hFF00_1000, 0, 1, 0, "R2");
      fetch(32'h0000_1000, 0, 0, 0, "R2");
      fetch(32'h0000_1000, 1, 2, 0, "R2");
      fetch(32'h0000_1002, 1, 0, 0, "R2");
      // R1: index conflict and top index
      fetch(32'h0000_1004, 0, 0, 0, "R1");
      fetch(32'h0000_2004, 0, 0, 0, "R1");
      fetch(32'h0000_1006, 0, 0, 0, "R1");
      fetch(32'h0000_10FC, 0, 3, 0, "R1");
      fetch(32'h0000_10FE, 0, 0, 0, "R1");
      // R7: disabled fetches bypass and do not fill
      cache_en = 1'b0;
      fetch(32'h0000_3000, 0, 0, 0, "R7");
      fetch(32'h0000_3000, 0, 1, 0, "R7");
      fetch(32'h0000_10FC, 0, 0, 0, "R7");
      cache_en = 1'b1;
      fetch(32'h0000_3000, 0, 0, 0, "R7");
      fetch(32'h0000_10FC, 0, 0, 0, "R7");
      // R8: invalidate alone, with request, on acknowledge
      pulse_inv();
      fetch(32'h0000_10FC, 0, 0, 0, "R8");
      fetch(32'h0000_10FC, 0, 0, 1, "R8");
      fetch(32'h0000_10FC, 0, 0, 0, "R8");
      fetch(32'h0000_2200, 0, 1, 2, "R8");
      fetch(32'h0000_2200, 0, 0, 0, "R8");

      for (int n = 0; n < 2500; n++) begin
         logic [7:0]  hi;
         logic [15:0] mid;
         logic [31:0] a;
         int          r = int'($urandom % 100);
         int          im = 0;
         case ($urandom % 4)
            0: hi = 8'h00; 1: hi = 8'hFF; 2: hi = 8'h01; default: hi = 8'h80;
         endcase
         mid = ($urandom % 2 == 0) ? 16'h0012 : 16'h3400;
         a = {hi, mid, 8'($urandom)};
         if (r < 4) cache_en = ~cache_en;
         else if (r < 6) im = 1;
         else if (r < 8) im = 2;
         if (r == 99) pulse_inv();
         fetch(a, ($urandom % 4) == 0, int'($urandom % 4), im, "R1 R6 R7 R8 random");
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule